// File: doc/BRIEF.md
# Two-Slot Ordered Queue with Single Action per Cycle

This block is a queue of depth two for words of a parameterised width. Two storage registers hold the data and a small controller tracks how many are occupied. On each rising clock edge the block does one thing only: it accepts a word, it releases a word, or it stays idle. It never does both in the same cycle. When a producer and a consumer request in the same cycle, the consumer wins and the offered word is discarded.

Back-pressure at the push side is advisory. The producer should watch `occ_full` and hold off. A push made while full is dropped without any signal. The pop side never stalls. A pop made while empty returns an all-zero word, so the consumer should watch `occ_empty` to tell real data from the zero fill. The released word appears on `data_out` one cycle after the pop and stays there until the next pop. `data_out` is driven only from registers, so there is no combinational path from `data_in`.

Reset is synchronous and active high. It empties the queue and clears `data_out`.

Top module: `fifo2_sq`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the queue becomes empty after that edge (`occ_empty`=1, `occ_half`=0, `occ_full`=0) and `data_out` becomes 0.
- R2: Exactly one of `occ_empty`, `occ_half`, `occ_full` is high at all times. They mean 0, 1 and 2 stored words respectively. The internal occupancy code is 2'b00 for empty, 2'b01 for one word and 2'b11 for full.
- R3: Words leave in the order they were accepted. After a pop from a non-empty queue, `data_out` shows the oldest stored word from the next cycle on.
- R4: When `push` and `pop` are both high, only the pop takes effect. Occupancy drops by one, or stays at zero, and the offered word is never stored.
- R5: A pop while empty sets `data_out` to all zeros after the edge, and the queue stays empty.
- R6: A push while full (with `pop` low) changes neither the occupancy nor the stored words. The next two pops return the two earlier words.
- R7: `data_out` changes only at an edge where `pop` was high (or at reset). `data_in` has no path to `data_out` that bypasses the storage registers.
- R8: A push with `pop` low moves the occupancy from empty to one word, or from one word to full. A pop moves it from full to one word, or from one word to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Request to store `data_in` |
| pop | input | 1 | Request to release the oldest word; has priority over `push` |
| data_in | input | WIDTH | Word offered by the producer |
| data_out | output | WIDTH | Last released word (zero after a pop while empty) |
| occ_empty | output | 1 | No words stored |
| occ_half | output | 1 | One word stored |
| occ_full | output | 1 | Two words stored |

## Verification
The bench targets these corner cases:

- **Push and pop together.** The bench drives both requests at every occupancy. A design that let the push through would grow the queue, or later return the offered word.
- **Push while full.** The bench pushes into a full queue and then drains it. A design that overwrote the second slot would return the rejected word on the second pop.
- **Pop from full.** The bench pops from a full queue and checks the order of what comes out. A design without the slot shift would repeat or skip a word.
- **Pop while empty.** The bench pops an empty queue after `data_out` has held non-zero data. A design that kept the stale value, or that underflowed the occupancy, is caught by the zero and flag checks.

// File: rtl/fifo2_pkg.sv
package fifo2_pkg;
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'b00,
    OCC_ONE   = 2'b01,
    OCC_FULL  = 2'b11
  } occ_t;
  localparam int unsigned SLOTS = 2;
endpackage

// File: rtl/fifo2_ctrl.sv
module fifo2_ctrl
  import fifo2_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic                   pop,
  output occ_t                   state_q,
  output logic [SLOTS-1:0]       wr_en,
  output logic                   shift,
  output logic                   take,
  output logic                   zero_fill
);
  occ_t       state_d;
  logic [1:0] code;

  assign code = state_q;

  always_comb begin
    state_d = state_q;
    if (pop) begin
      case (state_q)
        OCC_FULL: state_d = OCC_ONE;
        OCC_ONE:  state_d = OCC_EMPTY;
        default:  state_d = OCC_EMPTY;
      endcase
    end else if (push) begin
      case (state_q)
        OCC_EMPTY: state_d = OCC_ONE;
        OCC_ONE:   state_d = OCC_FULL;
        default:   state_d = OCC_FULL;
      endcase
    end
  end

  // slot enables: code+1 gives 01 (empty), 10 (one), 00 (full)
  assign wr_en     = (push && !pop) ? (code + 2'b01) : 2'b00;
  assign shift     = pop && (state_q == OCC_FULL);
  assign take      = pop && (state_q != OCC_EMPTY);
  assign zero_fill = pop && (state_q == OCC_EMPTY);

  always_ff @(posedge clk) begin
    if (rst) state_q <= OCC_EMPTY;
    else     state_q <= state_d;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state_q == OCC_EMPTY || state_q == OCC_ONE || state_q == OCC_FULL); // R2
  AST_POP_WINS: assert property (@(posedge clk) disable iff (rst)
    (push && pop && state_q == OCC_ONE) |=> state_q == OCC_EMPTY); // R4
  AST_EMPTY_POP_STAYS: assert property (@(posedge clk) disable iff (rst)
    (pop && state_q == OCC_EMPTY) |=> state_q == OCC_EMPTY); // R5
  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && state_q == OCC_FULL) |=> state_q == OCC_FULL); // R6
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && state_q == OCC_EMPTY) |=> state_q == OCC_ONE); // R8
endmodule

// File: rtl/fifo2_store.sv
module fifo2_store
  import fifo2_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] wr_en,
  input  logic             shift,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] head
);
  logic [WIDTH-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic             en;
    logic [WIDTH-1:0] nxt;
    if (g == SLOTS - 1) begin : g_tail
      assign en  = wr_en[g];
      assign nxt = data_in;
    end else begin : g_body
      assign en  = wr_en[g] | shift;
      assign nxt = shift ? slot_q[g+1] : data_in;
    end
    always_ff @(posedge clk) begin
      if (rst)     slot_q[g] <= '0;
      else if (en) slot_q[g] <= nxt;
    end
  end

  assign head = slot_q[0];

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(shift && (wr_en != '0))); // R4
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0 && !shift) |=> ($stable(slot_q[0]) && $stable(slot_q[1]))); // R6
endmodule

// File: rtl/fifo2_outsel.sv
module fifo2_outsel #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             zero_fill,
  input  logic             pop,
  input  logic [WIDTH-1:0] head,
  output logic [WIDTH-1:0] data_out
);
  always_ff @(posedge clk) begin
    if (rst)            data_out <= '0;
    else if (take)      data_out <= head;
    else if (zero_fill) data_out <= '0;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(data_out)); // R7
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    zero_fill |=> (data_out == '0)); // R5
  AST_POP_DECODE: assert property (@(posedge clk) disable iff (rst)
    pop |-> $onehot({take, zero_fill})); // R3
endmodule

// File: rtl/fifo2_sq.sv
module fifo2_sq
  import fifo2_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out,
  output logic             occ_empty,
  output logic             occ_half,
  output logic             occ_full
);
  occ_t             state_q;
  logic [SLOTS-1:0] wr_en;
  logic             shift, take, zero_fill;
  logic [WIDTH-1:0] head;

  fifo2_ctrl u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .state_q(state_q),
    .wr_en(wr_en), .shift(shift), .take(take), .zero_fill(zero_fill)
  );

  fifo2_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .shift(shift),
    .data_in(data_in), .head(head)
  );

  fifo2_outsel #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst), .take(take), .zero_fill(zero_fill), .pop(pop),
    .head(head), .data_out(data_out)
  );

  assign occ_empty = (state_q == OCC_EMPTY);
  assign occ_half  = (state_q == OCC_ONE);
  assign occ_full  = (state_q == OCC_FULL);

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot({occ_empty, occ_half, occ_full})); // R2
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (pop && occ_full) |=> occ_half); // R8
endmodule

// File: tb/tb_fifo2_sq.sv
module tb_fifo2_sq;
  localparam int W = 32;
  logic         clk = 1'b0;
  logic         rst, push, pop;
  logic [W-1:0] data_in, data_out;
  logic         occ_empty, occ_half, occ_full;

  int tests = 0, fails = 0;
  logic [W-1:0] mq [2];
  int           mcnt;
  logic [W-1:0] mout;

  always #2 clk = ~clk;

  fifo2_sq #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .data_in(data_in),
    .data_out(data_out), .occ_empty(occ_empty), .occ_half(occ_half),
    .occ_full(occ_full)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_flags(input int c);
    return {c == 0, c == 1, c == 2};
  endfunction

  // reference update from the requirements
  task automatic model(input bit pu, input bit po, input logic [W-1:0] d);
    if (po) begin
      if (mcnt == 0) mout = '0;
      else begin
        mout = mq[0]; mq[0] = mq[1]; mcnt--;
      end
    end else if (pu && mcnt < 2) begin
      mq[mcnt] = d; mcnt++;
    end
  endtask

  task automatic step(input bit pu, input bit po, input logic [W-1:0] d, input string req);
    @(negedge clk);
    push = pu; pop = po; data_in = d;
    @(posedge clk);
    model(pu, po, d);
    #1;
    chk({occ_empty, occ_half, occ_full} == exp_flags(mcnt), {req, " flags"},
        W'({occ_empty, occ_half, occ_full}), W'(exp_flags(mcnt)));
    chk(data_out == mout, {req, " data_out"}, data_out, mout);
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; push = 0; pop = 0; data_in = '0;
    mcnt = 0; mout = '0; mq[0] = '0; mq[1] = '0;
    repeat (2) @(posedge clk);
    #1;
    chk(occ_empty && !occ_half && !occ_full, "R1 reset flags", W'({occ_empty, occ_half, occ_full}), W'(3'b100));
    chk(data_out == '0, "R1 reset data_out", data_out, '0);
    @(negedge clk); rst = 1'b0;

    // R8 fill, R6 push while full dropped, R3 order on drain
    step(1, 0, 32'hA1A1_0001, "R8");
    step(1, 0, 32'hB2B2_0002, "R8");
    step(1, 0, 32'hDEAD_BEEF, "R6");
    step(0, 1, 32'h0, "R3");
    chk(data_out == 32'hA1A1_0001, "R3 first out", data_out, 32'hA1A1_0001);
    step(0, 1, 32'h0, "R6");
    chk(data_out == 32'hB2B2_0002, "R6 rejected word absent", data_out, 32'hB2B2_0002);
    // R7 hold while idle, even with changing data_in
    step(0, 0, 32'h1234_5678, "R7");
    chk(data_out == 32'hB2B2_0002, "R7 hold", data_out, 32'hB2B2_0002);
    // R5 pop empty returns zero
    step(0, 1, 32'h0, "R5");
    chk(data_out == '0 && occ_empty, "R5 zero on empty pop", data_out, '0);
    // R4 push+pop with one stored, and while empty
    step(1, 0, 32'h0000_0C0C, "R8");
    step(1, 1, 32'h5555_AAAA, "R4");
    chk(occ_empty && data_out == 32'h0000_0C0C, "R4 pop wins", data_out, 32'h0000_0C0C);
    step(1, 1, 32'h7777_7777, "R4");
    chk(occ_empty && data_out == '0, "R4 pop wins when empty", data_out, '0);
    // R4 with full
    step(1, 0, 32'h11, "R8");
    step(1, 0, 32'h22, "R8");
    step(1, 1, 32'h99, "R4");
    step(0, 1, 32'h0, "R4");
    chk(data_out == 32'h22 && occ_empty, "R4 offered word not stored", data_out, 32'h22);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 55, (r >= 40 && r < 80) || r >= 95, $urandom, "R3");
    end

    // R1 mid-run reset
    step(1, 0, 32'hFACE, "R8");
    @(negedge clk); rst = 1'b1; push = 0; pop = 0;
    @(posedge clk); #1;
    mcnt = 0; mout = '0;
    chk(occ_empty && data_out == '0, "R1 reset mid-run", data_out, '0);
    @(negedge clk); rst = 1'b0;
    step(0, 1, 32'h0, "R5");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule